// File: doc/BRIEF.md
# ATA DMA Host Strobe Sequencer

This block is the host side of a multiword DMA data transfer to or from an ATA-style drive. The drive raises an active-high DMA request. The host enables a transfer with a start input. The sequencer then lowers an active-low acknowledge and runs one or more data cycles. In each cycle it pulses an active-low read strobe or write strobe, and the widths of that pulse are set by one of three timing modes. All pulse lengths are counted in cycles of a 10 ns core clock. Each nanosecond minimum is rounded up to whole cycles, so no minimum is ever cut short.

A burst works in demand fashion. The drive holds its request high for as long as it wants more cycles. The sequencer looks at the request only in the final cycle of each inactive gap. Every gap is at least 40 ns long, so a request that falls just after a strobe edge has settled before it is read.

For reads, the word on the data bus is latched on the clock edge where the read strobe rises. For writes, the word is taken when the write strobe falls and is held on the bus until the strobe rises. When the request is found low, the acknowledge is released and a one-clock done pulse is given.

Top module: `ata_dma_host_seq`

## Requirements
- R1: While reset is asserted, the acknowledge, read strobe and write strobe are high (inactive), and done, the data output enable, the read data and the write data output are all zero.
- R2: When start and the request are both high at a clock edge while the sequencer is idle, the acknowledge goes low after that edge. It stays low for exactly one cycle with both strobes high before the first strobe falls. If start is high while the request is low, nothing happens and the acknowledge stays high.
- R3: Each strobe stays low for exactly ceil(T/10 ns) cycles: 47 cycles in mode 0 (T = 470 ns), 23 cycles in mode 1 (230 ns) and 11 cycles in mode 2 (110 ns). The mode input value 3 uses the mode 2 timing.
- R4: After a read strobe, both strobes stay high with the acknowledge low for 19 cycles in mode 0, 10 cycles in mode 1 and 5 cycles in mode 2 (45 ns).
- R5: After a write strobe, the inactive gap is 47 cycles in mode 0, 23 cycles in mode 1 and 11 cycles in mode 2 (110 ns).
- R6: The request is sampled only at the edge that ends an inactive gap, which is never less than 4 cycles (40 ns) after the strobe rose. If it is high there, the next strobe falls right after that edge. Request changes at any other time have no effect.
- R7: If the request is low at the end of a gap, the acknowledge goes high at the next edge. Done is high for exactly that one cycle.
- R8: During a read (direction 0), the read data output takes the value on the data input at the edge where the read strobe rises. It holds that value until the next such edge.
- R9: During a write (direction 1), the data output takes the write data input at the edge where the write strobe falls. It holds that word while the strobe is low, even if the write data input changes. The output enable is high exactly while the write strobe is low.
- R10: Mode and direction are latched when the burst starts, and later changes have no effect until the next burst. The two strobes are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one count per period |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Transfer enable, sampled while idle |
| dma_req | input | 1 | Drive DMA request, active high |
| xfer_mode | input | 2 | Timing mode 0, 1, 2 (3 behaves as 2) |
| dir_wr | input | 1 | 1 = host writes to drive, 0 = host reads |
| wr_data | input | 16 | Word to send in the next write cycle |
| dd_in | input | 16 | Data bus value driven by the drive |
| dma_ack_n | output | 1 | DMA acknowledge, active low |
| rd_stb_n | output | 1 | Read strobe, active low |
| wr_stb_n | output | 1 | Write strobe, active low |
| dd_out | output | 16 | Data bus value driven by the host |
| dd_oe | output | 1 | Host drive enable for the data bus |
| rd_data | output | 16 | Last word captured from the drive |
| done | output | 1 | One-cycle pulse when a burst ends |

## Verification
Each result is due a fixed number of edges after its cause. The acknowledge falls one edge after start is accepted, and the first strobe follows one edge later. Every strobe low time and every gap lasts exactly its table count. The captured read word and the released strobe appear together, and done and the released acknowledge come one edge after the final gap. The bench drives inputs and samples outputs on the falling clock edge. It steps through the cycle counts it expects for the mode and direction and checks the strobe level on every cycle of each phase. It also places the true read word on the bus only in the last low cycle and changes the write word during the pulse, so an edge that lands one cycle early or late is seen.

// File: rtl/ata_dma_pkg.sv
package ata_dma_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_ACK,
      SQ_PULSE,
      SQ_GAP,
      SQ_END
   } seq_state_e;

   // round a nanosecond minimum up to whole clock periods
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
      return (ns + per - 1) / per;
   endfunction

   function automatic int unsigned max_of3(input int unsigned v [3]);
      int unsigned m;
      m = v[0];
      for (int i = 1; i < 3; i++) if (v[i] > m) m = v[i];
      return m;
   endfunction

endpackage

// File: rtl/ata_dma_timing.sv
module ata_dma_timing
   import ata_dma_pkg::*;
#(
   parameter int unsigned CLK_NS    = 10,
   parameter int unsigned CNT_W     = 6,
   parameter int unsigned PULSE_NS  [3] = '{470, 230, 110},
   parameter int unsigned RD_GAP_NS [3] = '{190, 95, 45},
   parameter int unsigned WR_GAP_NS [3] = '{470, 230, 110}
) (
   input  logic [1:0]       mode_q,
   input  logic             wr_q,
   output logic [CNT_W-1:0] pulse_cyc,
   output logic [CNT_W-1:0] gap_cyc
);

   logic [CNT_W-1:0] pulse_tab [4];
   logic [CNT_W-1:0] rgap_tab  [4];
   logic [CNT_W-1:0] wgap_tab  [4];

   // code 3 reuses the fastest mode
   for (genvar g = 0; g < 4; g++) begin : g_mode
      localparam int unsigned IDX = (g > 2) ? 2 : g;
      assign pulse_tab[g] = CNT_W'(ns_to_cyc(PULSE_NS[IDX], CLK_NS));
      assign rgap_tab[g]  = CNT_W'(ns_to_cyc(RD_GAP_NS[IDX], CLK_NS));
      assign wgap_tab[g]  = CNT_W'(ns_to_cyc(WR_GAP_NS[IDX], CLK_NS));
   end

   assign pulse_cyc = pulse_tab[mode_q];
   assign gap_cyc   = wr_q ? wgap_tab[mode_q] : rgap_tab[mode_q];

endmodule

// File: rtl/ata_dma_fsm.sv
module ata_dma_fsm
   import ata_dma_pkg::*;
#(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             dma_req,
   input  logic [1:0]       xfer_mode,
   input  logic             dir_wr,
   input  logic [CNT_W-1:0] pulse_cyc,
   input  logic [CNT_W-1:0] gap_cyc,
   output seq_state_e       state,
   output logic [1:0]       mode_q,
   output logic             wr_q,
   output logic             pulse_last,
   output logic             pulse_enter
);

   logic [CNT_W-1:0] cnt;
   logic             cnt_zero;

   assign cnt_zero    = (cnt == '0);
   assign pulse_last  = (state == SQ_PULSE) && cnt_zero;
   assign pulse_enter = (state == SQ_ACK) || ((state == SQ_GAP) && cnt_zero && dma_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         cnt    <= '0;
         mode_q <= '0;
         wr_q   <= 1'b0;
      end else begin
         unique case (state)
            SQ_IDLE: if (start && dma_req) begin
               state  <= SQ_ACK;
               mode_q <= xfer_mode;
               wr_q   <= dir_wr;
            end
            SQ_ACK: begin
               state <= SQ_PULSE;
               cnt   <= pulse_cyc - CNT_W'(1);
            end
            SQ_PULSE: if (cnt_zero) begin
               state <= SQ_GAP;
               cnt   <= gap_cyc - CNT_W'(1);
            end else begin
               cnt <= cnt - CNT_W'(1);
            end
            SQ_GAP: if (cnt_zero) begin
               if (dma_req) begin
                  state <= SQ_PULSE;
                  cnt   <= pulse_cyc - CNT_W'(1);
               end else begin
                  state <= SQ_END;
               end
            end else begin
               cnt <= cnt - CNT_W'(1);
            end
            SQ_END:  state <= SQ_IDLE;
            default: state <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ata_dma_datapath.sv
module ata_dma_datapath #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic              load_en,
   input  logic [DATA_W-1:0] dd_in,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] dd_out
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         dd_out  <= '0;
      end else begin
         if (cap_en)  rd_data <= dd_in;
         if (load_en) dd_out  <= wr_data;
      end
   end

endmodule

// File: rtl/ata_dma_host_seq.sv
module ata_dma_host_seq
   import ata_dma_pkg::*;
#(
   parameter int unsigned CLK_NS    = 10,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned SETTLE_NS = 40,
   parameter int unsigned PULSE_NS  [3] = '{470, 230, 110},
   parameter int unsigned RD_GAP_NS [3] = '{190, 95, 45},
   parameter int unsigned WR_GAP_NS [3] = '{470, 230, 110}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dma_req,
   input  logic [1:0]        xfer_mode,
   input  logic              dir_wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] dd_in,
   output logic              dma_ack_n,
   output logic              rd_stb_n,
   output logic              wr_stb_n,
   output logic [DATA_W-1:0] dd_out,
   output logic              dd_oe,
   output logic [DATA_W-1:0] rd_data,
   output logic              done
);

   localparam int unsigned MAX_NS  = (max_of3(PULSE_NS) > max_of3(WR_GAP_NS)) ?
                                     max_of3(PULSE_NS) : max_of3(WR_GAP_NS);
   localparam int unsigned MAX_ALL = (MAX_NS > max_of3(RD_GAP_NS)) ? MAX_NS : max_of3(RD_GAP_NS);
   localparam int unsigned MAX_CYC = ns_to_cyc(MAX_ALL, CLK_NS);
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
   localparam int unsigned SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_NS);

   if (CLK_NS == 0 || DATA_W == 0) begin : g_bad_base
      $error("clock period and data width must be nonzero");
   end
   for (genvar g = 0; g < 3; g++) begin : g_param_chk
      if (PULSE_NS[g] == 0) begin : g_bad_pulse
         $error("pulse width must be nonzero");
      end
      if (ns_to_cyc(RD_GAP_NS[g], CLK_NS) < SETTLE_CYC ||
          ns_to_cyc(WR_GAP_NS[g], CLK_NS) < SETTLE_CYC) begin : g_bad_gap
         $error("inactive gap shorter than the request settle delay");
      end
   end

   seq_state_e       state;
   logic [1:0]       mode_q;
   logic             wr_q;
   logic             pulse_last;
   logic             pulse_enter;
   logic [CNT_W-1:0] pulse_cyc;
   logic [CNT_W-1:0] gap_cyc;
   logic             pulsing;

   ata_dma_timing #(
      .CLK_NS   (CLK_NS),
      .CNT_W    (CNT_W),
      .PULSE_NS (PULSE_NS),
      .RD_GAP_NS(RD_GAP_NS),
      .WR_GAP_NS(WR_GAP_NS)
   ) u_timing (
      .mode_q   (mode_q),
      .wr_q     (wr_q),
      .pulse_cyc(pulse_cyc),
      .gap_cyc  (gap_cyc)
   );

   ata_dma_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .dma_req    (dma_req),
      .xfer_mode  (xfer_mode),
      .dir_wr     (dir_wr),
      .pulse_cyc  (pulse_cyc),
      .gap_cyc    (gap_cyc),
      .state      (state),
      .mode_q     (mode_q),
      .wr_q       (wr_q),
      .pulse_last (pulse_last),
      .pulse_enter(pulse_enter)
   );

   ata_dma_datapath #(.DATA_W(DATA_W)) u_data (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (pulse_last && !wr_q),
      .load_en(pulse_enter && wr_q),
      .dd_in  (dd_in),
      .wr_data(wr_data),
      .rd_data(rd_data),
      .dd_out (dd_out)
   );

   assign pulsing   = (state == SQ_PULSE);
   assign dma_ack_n = !((state == SQ_ACK) || pulsing || (state == SQ_GAP));
   assign rd_stb_n  = !(pulsing && !wr_q);
   assign wr_stb_n  = !(pulsing && wr_q);
   assign dd_oe     = pulsing && wr_q;
   assign done      = (state == SQ_END);

endmodule

// File: rtl/ata_dma_host_seq_chk.sv
module ata_dma_host_seq_chk #(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned SETTLE_CYC = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dma_ack_n,
   input logic              rd_stb_n,
   input logic              wr_stb_n,
   input logic              dd_oe,
   input logic [DATA_W-1:0] dd_out,
   input logic [DATA_W-1:0] dd_in,
   input logic [DATA_W-1:0] rd_data,
   input logic              done
);

   logic [7:0] idle_run;
   logic       had_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_run <= '0;
         had_stb  <= 1'b0;
      end else begin
         if (!dma_ack_n && rd_stb_n && wr_stb_n) begin
            if (idle_run != 8'hFF) idle_run <= idle_run + 8'd1;
         end else begin
            idle_run <= '0;
         end
         if (dma_ack_n) had_stb <= 1'b0;
         else if (!rd_stb_n || !wr_stb_n) had_stb <= 1'b1;
      end
   end

   // R10
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_stb_n && !wr_stb_n));

   // R2
   stb_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stb_n || !wr_stb_n) |-> !dma_ack_n);

   // R2
   ack_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dma_ack_n) |-> (rd_stb_n && wr_stb_n));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_ack_n) |-> done);

   // R8
   rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_stb_n) |-> (rd_data == $past(dd_in)));

   // R9
   oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dd_oe == !wr_stb_n);

   // R9
   wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stb_n && !$past(wr_stb_n)) |-> $stable(dd_out));

   // R6
   req_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (had_stb && ($fell(rd_stb_n) || $fell(wr_stb_n))) |-> (idle_run >= 8'(SETTLE_CYC)));

endmodule

bind ata_dma_host_seq ata_dma_host_seq_chk #(
   .DATA_W    (DATA_W),
   .SETTLE_CYC(SETTLE_CYC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dma_ack_n(dma_ack_n),
   .rd_stb_n (rd_stb_n),
   .wr_stb_n (wr_stb_n),
   .dd_oe    (dd_oe),
   .dd_out   (dd_out),
   .dd_in    (dd_in),
   .rd_data  (rd_data),
   .done     (done)
);

// File: tb/tb_ata_dma_host_seq.sv
module tb_ata_dma_host_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        dma_req = 1'b0;
   logic [1:0]  xfer_mode = 2'd0;
   logic        dir_wr = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] dd_in = '0;
   logic        dma_ack_n, rd_stb_n, wr_stb_n, dd_oe, done;
   logic [15:0] dd_out, rd_data;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   ata_dma_host_seq dut (
      .clk(clk), .rst_n(rst_n), .start(start), .dma_req(dma_req),
      .xfer_mode(xfer_mode), .dir_wr(dir_wr), .wr_data(wr_data), .dd_in(dd_in),
      .dma_ack_n(dma_ack_n), .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n),
      .dd_out(dd_out), .dd_oe(dd_oe), .rd_data(rd_data), .done(done)
   );

   function automatic int exp_pulse(input int m);
      case (m)
         0: return 47;
         1: return 23;
         default: return 11;
      endcase
   endfunction

   function automatic int exp_gap(input int m, input bit wr);
      if (wr) return exp_pulse(m);
      case (m)
         0: return 19;
         1: return 10;
         default: return 5;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run_burst(input int m, input bit wr, input int beats);
      int pw, gw, bad, badw;
      logic [15:0] wp, rp;
      bit glitch;
      pw = exp_pulse(m);
      gw = exp_gap(m, wr);
      xfer_mode = 2'(m); dir_wr = wr; dma_req = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      xfer_mode = 2'($urandom);
      dir_wr = ~wr;
      // R2 one acknowledge cycle with strobes idle
      chk(!dma_ack_n && rd_stb_n && wr_stb_n, "R2 ack lead", {dma_ack_n, rd_stb_n, wr_stb_n}, 3'b011);
      for (int b = 0; b < beats; b++) begin
         wp = 16'($urandom);
         rp = 16'($urandom);
         glitch = ($urandom % 2) == 1;
         wr_data = wp;
         dd_in = ~rp;
         @(negedge clk);
         // R6 continuation / R10 direction from latched value
         chk(wr ? (!wr_stb_n && rd_stb_n) : (!rd_stb_n && wr_stb_n),
             (b == 0) ? "R10 first strobe" : "R6 next strobe",
             {rd_stb_n, wr_stb_n}, wr ? 2'b10 : 2'b01);
         if (wr) chk(dd_oe && dd_out == wp, "R9 write word", dd_out, wp);
         wr_data = ~wp;
         if (b == beats - 1 || glitch) dma_req = 1'b0;
         bad = 0; badw = 0;
         for (int k = 2; k <= pw; k++) begin
            @(negedge clk);
            if ((wr ? wr_stb_n : rd_stb_n) !== 1'b0) bad++;
            if (wr && (dd_out !== wp || dd_oe !== 1'b1)) badw++;
            if (k == pw) dd_in = rp;
         end
         chk(bad == 0, "R3 pulse held", bad, 0);
         if (wr) chk(badw == 0, "R9 word held", badw, 0);
         @(negedge clk);
         chk(rd_stb_n && wr_stb_n && !dma_ack_n, "R3 pulse width", {rd_stb_n, wr_stb_n}, 2'b11);
         if (!wr) chk(rd_data == rp, "R8 read capture", rd_data, rp);
         chk(!dd_oe, "R9 enable off", dd_oe, 0);
         dd_in = 16'($urandom);
         if (b != beats - 1 && glitch) dma_req = 1'b1;
         bad = 0;
         for (int k = 2; k <= gw; k++) begin
            @(negedge clk);
            if (rd_stb_n !== 1'b1 || wr_stb_n !== 1'b1 || dma_ack_n !== 1'b0) bad++;
         end
         chk(bad == 0, wr ? "R5 write gap" : "R4 read gap", bad, 0);
      end
      @(negedge clk);
      chk(dma_ack_n && done && rd_stb_n && wr_stb_n, "R7 end of burst", {dma_ack_n, done}, 2'b11);
      @(negedge clk);
      chk(dma_ack_n && !done, "R7 done one cycle", done, 0);
   endtask

   initial begin
      int seed_init;
      seed_init = $urandom(32'h1A2B3C);
      repeat (3) @(negedge clk);
      // R1
      chk(dma_ack_n && rd_stb_n && wr_stb_n && !done && !dd_oe && rd_data == 0 && dd_out == 0,
          "R1 reset state", {dma_ack_n, rd_stb_n, wr_stb_n, done, dd_oe}, 5'b11100);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 start without request is ignored
      start = 1'b1; dma_req = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(dma_ack_n && rd_stb_n && wr_stb_n, "R2 no request ignored", dma_ack_n, 1);
      end
      start = 1'b0;
      @(negedge clk);
      run_burst(0, 1'b0, 1);
      run_burst(0, 1'b1, 2);
      run_burst(1, 1'b0, 2);
      run_burst(1, 1'b1, 1);
      run_burst(2, 1'b0, 3);
      run_burst(2, 1'b1, 3);
      run_burst(3, 1'b0, 2);
      run_burst(3, 1'b1, 1);
      for (int n = 0; n < 14; n++) begin
         run_burst(int'($urandom % 4), 1'($urandom), int'($urandom % 4) + 1);
         repeat (int'($urandom % 3)) @(negedge clk);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule